// File: doc/BRIEF.md
# Uncorrectable Error Header Log Queue

This block keeps the logging state for uncorrectable errors in an error-reporting function. Each error arrives as a record: a status vector that names the error, four header dwords, four prefix dwords, and flags that say whether the header and the prefix are valid. The block keeps the uncorrectable status register. It also keeps a pointer to the bit of the error that is logged, a header log, a prefix log and a flag that shows the prefix log holds data.

When multiple header recording is switched on, records that arrive while the logged error is still pending go into a first-in first-out queue. They stay hidden behind the pointer. Software retires the logged error by clearing its status bit with a write-one-to-clear access. The block then promotes the oldest queued record into the logs. It also sets again the status bits of every record still waiting, so that a write cannot wipe out the status of a queued error. If a record arrives when the queue is full, it is dropped and a one-cycle overflow pulse is raised. Mask handling and error messages belong to the blocks around this one.

Top module: `hdr_log_queue`

## Requirements
- R1: After reset, the status register, pointer, header log, prefix log, prefix flag, overflow pulse and queue count are all zero.
- R2: A record that is logged directly loads the pointer with the index of the lowest set bit of its status. Every accepted record ORs its status into the status register one cycle after it is presented, whether it is logged, queued or dropped.
- R3: When a record's header-valid flag is set, header log dword i (bits 32*i+31 down to 32*i) gets input dword i with its four bytes in reversed order. When the flag is clear, the header log becomes zero.
- R4: The prefix log gets the byte-reversed prefix dwords and the prefix flag is set only when the record's prefix-present flag and the prefix enable input are both high. Otherwise the prefix log is zeroed and the flag is cleared.
- R5: A record is queued, and the logs and pointer stay unchanged, when multiple header recording is enabled and the status bit at the pointer is set. The count goes up by one. When recording is disabled, the record overwrites the logs instead.
- R6: A record that would be queued while the count equals DEPTH is dropped. The count stays the same and the overflow output is high for exactly one cycle, on the cycle after the record.
- R7: A status write that clears the pointed-to bit while recording is enabled and the queue is not empty pops the oldest record into the logs, in first-in first-out order. The status bits of all records that were queued before the pop are set again.
- R8: A status write that clears the pointed-to bit while recording is disabled or the queue is empty clears the header log, prefix log, prefix flag and pointer.
- R9: A status write that leaves the pointed-to bit set while recording is enabled clears the written bits, except bits that belong to queued records, which stay set.
- R10: A status write that leaves the pointed-to bit set while recording is disabled empties the queue.
- R11: The multiple-header-recording capable output is high exactly when DEPTH is greater than zero.
- R12: A record presented in the same cycle as a status write is ignored. Status, logs and count follow the write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recValid | input | 1 | Record write request |
| recStatus | input | 32 | Status vector of the record |
| recHdrValid | input | 1 | Record carries a valid header |
| recPfxPresent | input | 1 | Record carries a prefix |
| recHdr | input | 128 | Header dwords, dword i at bits 32*i+31:32*i |
| recPfx | input | 128 | Prefix dwords, same layout |
| mhrEnable | input | 1 | Multiple header recording enabled |
| pfxEnable | input | 1 | End-to-end prefixes enabled |
| swWrValid | input | 1 | Software write to the status register |
| swWrData | input | 32 | Write-one-to-clear data |
| uncorStatus | output | 32 | Uncorrectable status register |
| firstErrPtr | output | 5 | Index of the logged error's status bit |
| hdrLog | output | 128 | Header log, bytes reversed per dword |
| pfxLog | output | 128 | Prefix log, bytes reversed per dword |
| pfxLogged | output | 1 | Prefix log holds a prefix |
| overflowPulse | output | 1 | One-cycle pulse when a record is dropped |
| queueCount | output | 3 | Number of queued records |
| mhrCapable | output | 1 | Multiple header recording supported |

## Verification
The bench goes after the promotion path. It queues two records behind a logged one and retires them one at a time. A design that popped the newest entry first, or that did not set the queued status bits again, would show the wrong header or a lost status bit. It also writes ones to the bits of queued errors while the logged error is still pending. A design that let those bits clear would lose errors that are still waiting. It fills the queue and offers one more record, which catches a missing or stretched overflow pulse and a count that wraps. Last, it checks the byte order of the header and prefix logs, the prefix gating on the enable input, and a status write that collides with a record.

// File: rtl/hlq_pkg.sv
package hlq_pkg;
  parameter int HLQ_SW = 32;
  parameter int HLQ_DW = 32;
  parameter int HLQ_ND = 4;
  localparam int HLQ_PW = $clog2(HLQ_SW);
  localparam int HLQ_LW = HLQ_DW * HLQ_ND;
  localparam int HLQ_BPD = HLQ_DW / 8;

  typedef struct packed {
    logic [HLQ_SW-1:0] status;
    logic              hdrValid;
    logic              pfxPresent;
    logic [HLQ_LW-1:0] hdr;
    logic [HLQ_LW-1:0] pfx;
  } hlqRec_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic drop;
    logic loadIn;
    logic loadHead;
    logic clearLog;
    logic reassert;
    logic applyWr;
    logic mergeIn;
  } hlqCtl_t;

  function automatic logic [HLQ_PW-1:0] lowestBit(input logic [HLQ_SW-1:0] s);
    lowestBit = '0;
    for (int i = HLQ_SW - 1; i >= 0; i--) begin
      if (s[i]) lowestBit = HLQ_PW'(i);
    end
  endfunction

  function automatic logic [HLQ_LW-1:0] swapDwords(input logic [HLQ_LW-1:0] x);
    swapDwords = '0;
    for (int d = 0; d < HLQ_ND; d++) begin
      for (int b = 0; b < HLQ_BPD; b++) begin
        swapDwords[d*HLQ_DW + 8*b +: 8] = x[d*HLQ_DW + 8*(HLQ_BPD-1-b) +: 8];
      end
    end
  endfunction
endpackage

// File: rtl/hlq_ctrl.sv
module hlq_ctrl
  import hlq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              recValid,
  input  logic              swWrValid,
  input  logic [HLQ_SW-1:0] swWrData,
  input  logic              mhrEnable,
  input  logic [HLQ_SW-1:0] statusReg,
  input  logic [HLQ_PW-1:0] fep,
  input  logic [CW-1:0]     count,
  output hlqCtl_t           ctl
);
  logic [HLQ_SW-1:0] afterWr;
  logic ptrHeld, queueFull, queueEmpty;

  assign afterWr    = statusReg & ~swWrData;
  assign ptrHeld    = afterWr[fep];
  assign queueFull  = (count == CW'(DEPTH));
  assign queueEmpty = (count == '0);

  always_comb begin
    ctl = '0;
    if (swWrValid) begin
      ctl.applyWr = 1'b1;
      if (!ptrHeld) begin
        if (mhrEnable && !queueEmpty) begin
          ctl.reassert = 1'b1;
          ctl.pop      = 1'b1;
          ctl.loadHead = 1'b1;
        end else begin
          ctl.clearLog = 1'b1;
        end
      end else if (mhrEnable) begin
        ctl.reassert = 1'b1;
      end else begin
        ctl.flush = 1'b1;
      end
    end else if (recValid) begin
      ctl.mergeIn = 1'b1;
      if (mhrEnable && statusReg[fep]) begin
        if (queueFull) ctl.drop = 1'b1;
        else           ctl.push = 1'b1;
      end else begin
        ctl.loadIn = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hlq_dp.sv
module hlq_dp
  import hlq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hlqCtl_t           ctl,
  input  hlqRec_t           rec,
  input  logic [HLQ_SW-1:0] swWrData,
  input  logic              pfxEnable,
  output logic [HLQ_SW-1:0] statusReg,
  output logic [HLQ_PW-1:0] fep,
  output logic [HLQ_LW-1:0] hdrLog,
  output logic [HLQ_LW-1:0] pfxLog,
  output logic              pfxLogged,
  output logic              ovfl,
  output logic [CW-1:0]     count
);
  hlqRec_t           headRec, srcRec;
  logic [HLQ_SW-1:0] queuedOr, nextStatus;
  logic              usePfx;

  if (DEPTH > 0) begin : g_fifo
    hlqRec_t        mem [DEPTH];
    logic [AW-1:0]  head, tail;
    logic [CW-1:0]  cnt;

    assign headRec = mem[head];
    assign count   = cnt;

    always_comb begin
      queuedOr = '0;
      for (int k = 0; k < DEPTH; k++) begin
        if (CW'(k) < cnt) queuedOr |= mem[AW'((int'(head) + k) % DEPTH)].status;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        head <= '0;
        tail <= '0;
        cnt  <= '0;
      end else if (ctl.flush) begin
        head <= '0;
        tail <= '0;
        cnt  <= '0;
      end else if (ctl.push) begin
        mem[tail] <= rec;
        tail      <= (tail == AW'(DEPTH - 1)) ? '0 : tail + 1'b1;
        cnt       <= cnt + 1'b1;
      end else if (ctl.pop) begin
        head <= (head == AW'(DEPTH - 1)) ? '0 : head + 1'b1;
        cnt  <= cnt - 1'b1;
      end
    end
  end else begin : g_nofifo
    assign headRec  = '0;
    assign count    = '0;
    assign queuedOr = '0;
  end

  assign srcRec = ctl.loadHead ? headRec : rec;
  assign usePfx = srcRec.pfxPresent && pfxEnable;

  always_comb begin
    nextStatus = statusReg;
    if (ctl.applyWr) begin
      nextStatus = statusReg & ~swWrData;
      if (ctl.reassert) nextStatus |= queuedOr;
    end else if (ctl.mergeIn) begin
      nextStatus = statusReg | rec.status;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      fep       <= '0;
      hdrLog    <= '0;
      pfxLog    <= '0;
      pfxLogged <= 1'b0;
      ovfl      <= 1'b0;
    end else begin
      statusReg <= nextStatus;
      ovfl      <= ctl.drop;
      if (ctl.loadIn || ctl.loadHead) begin
        fep       <= lowestBit(srcRec.status);
        hdrLog    <= srcRec.hdrValid ? swapDwords(srcRec.hdr) : '0;
        pfxLog    <= usePfx ? swapDwords(srcRec.pfx) : '0;
        pfxLogged <= usePfx;
      end else if (ctl.clearLog) begin
        fep       <= '0;
        hdrLog    <= '0;
        pfxLog    <= '0;
        pfxLogged <= 1'b0;
      end
    end
  end

  // R5: occupancy never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R5: a queued record grows the queue and leaves the logs alone
  p_push_hidden_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |=> (count == CW'($past(count) + 1'b1)) && $stable(hdrLog) && $stable(fep));

  // R6: a dropped record raises the pulse and leaves the count
  p_no_overflow_loss_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drop |=> ovfl && $stable(count));

  // R7: promotion removes exactly one entry
  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |=> count == CW'($past(count) - 1'b1));

  // R8: clearing empties every log field
  p_clear_logs_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearLog |=> (fep == '0) && !pfxLogged && (hdrLog == '0) && (pfxLog == '0));

  // R10: a flush leaves an empty queue
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> count == '0);
endmodule

// File: rtl/hdr_log_queue.sv
module hdr_log_queue
  import hlq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recValid,
  input  logic [HLQ_SW-1:0] recStatus,
  input  logic              recHdrValid,
  input  logic              recPfxPresent,
  input  logic [HLQ_LW-1:0] recHdr,
  input  logic [HLQ_LW-1:0] recPfx,
  input  logic              mhrEnable,
  input  logic              pfxEnable,
  input  logic              swWrValid,
  input  logic [HLQ_SW-1:0] swWrData,
  output logic [HLQ_SW-1:0] uncorStatus,
  output logic [HLQ_PW-1:0] firstErrPtr,
  output logic [HLQ_LW-1:0] hdrLog,
  output logic [HLQ_LW-1:0] pfxLog,
  output logic              pfxLogged,
  output logic              overflowPulse,
  output logic [CW-1:0]     queueCount,
  output logic              mhrCapable
);
  hlqCtl_t ctl;
  hlqRec_t rec;

  assign rec = '{status: recStatus, hdrValid: recHdrValid, pfxPresent: recPfxPresent,
                 hdr: recHdr, pfx: recPfx};
  assign mhrCapable = (DEPTH > 0);

  hlq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .recValid (recValid),
    .swWrValid(swWrValid),
    .swWrData (swWrData),
    .mhrEnable(mhrEnable),
    .statusReg(uncorStatus),
    .fep      (firstErrPtr),
    .count    (queueCount),
    .ctl      (ctl)
  );

  hlq_dp #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rec      (rec),
    .swWrData (swWrData),
    .pfxEnable(pfxEnable),
    .statusReg(uncorStatus),
    .fep      (firstErrPtr),
    .hdrLog   (hdrLog),
    .pfxLog   (pfxLog),
    .pfxLogged(pfxLogged),
    .ovfl     (overflowPulse),
    .count    (queueCount)
  );
endmodule

// File: tb/sim_hdr_log_queue.sv
`timescale 1ns/1ps
module sim_hdr_log_queue;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         recValid = 1'b0, recHdrValid = 1'b0, recPfxPresent = 1'b0;
  logic [31:0]  recStatus = '0;
  logic [127:0] recHdr = '0, recPfx = '0;
  logic         mhrEnable = 1'b0, pfxEnable = 1'b0;
  logic         swWrValid = 1'b0;
  logic [31:0]  swWrData = '0;
  logic [31:0]  uncorStatus;
  logic [4:0]   firstErrPtr;
  logic [127:0] hdrLog, pfxLog;
  logic         pfxLogged, overflowPulse, mhrCapable;
  logic [2:0]   queueCount;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hdr_log_queue u0 (.*);

  function automatic logic [127:0] mkHdr(input logic [7:0] tag);
    for (int i = 0; i < 4; i++) mkHdr[32*i +: 32] = {tag, 8'(i), 8'hA5, 8'h3C};
  endfunction
  function automatic logic [127:0] mkPfx(input logic [7:0] tag);
    for (int i = 0; i < 4; i++) mkPfx[32*i +: 32] = {8'hE0 | 8'(i), tag, 8'h5A, 8'h81};
  endfunction
  function automatic logic [127:0] rev(input logic [127:0] x);
    for (int i = 0; i < 4; i++)
      rev[32*i +: 32] = {x[32*i +: 8], x[32*i+8 +: 8], x[32*i+16 +: 8], x[32*i+24 +: 8]};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; recValid = 0; swWrValid = 0; mhrEnable = 0; pfxEnable = 0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendRec(input logic [31:0] st, input logic hv, input logic pp, input logic [7:0] tag);
    @(negedge clk);
    recValid = 1; recStatus = st; recHdrValid = hv; recPfxPresent = pp;
    recHdr = mkHdr(tag); recPfx = mkPfx(tag);
    @(negedge clk);
    recValid = 0;
  endtask

  task automatic swWrite(input logic [31:0] d);
    @(negedge clk);
    swWrValid = 1; swWrData = d;
    @(negedge clk);
    swWrValid = 0;
  endtask

  task automatic tReset();
    doReset();
    check("R1 status", uncorStatus, 0);
    check("R1 ptr", firstErrPtr, 0);
    check("R1 hdr", hdrLog, 0);
    check("R1 pfx", {pfxLog, pfxLogged, overflowPulse}, 0);
    check("R1 count", queueCount, 0);
    check("R11 capable", mhrCapable, 1);
  endtask

  task automatic tDirectLog();
    doReset();
    pfxEnable = 1;
    sendRec(32'h10, 1, 1, 8'h11);
    check("R2 ptr", firstErrPtr, 4);
    check("R2 status", uncorStatus, 32'h10);
    check("R3 hdr swapped", hdrLog, rev(mkHdr(8'h11)));
    check("R4 pfx swapped", pfxLog, rev(mkPfx(8'h11)));
    check("R4 flag set", pfxLogged, 1);
    pfxEnable = 0;
    sendRec(32'h200, 0, 1, 8'h22);
    check("R5 overwrite when disabled ptr", firstErrPtr, 9);
    check("R3 hdr zero", hdrLog, 0);
    check("R4 pfx gated", {pfxLog, pfxLogged}, 0);
    check("R2 status merge", uncorStatus, 32'h210);
    swWrite(32'h200);
    check("R8 cleared ptr", firstErrPtr, 0);
    check("R8 cleared logs", {hdrLog, pfxLogged}, 0);
    check("R8 status", uncorStatus, 32'h10);
    sendRec(32'hC00, 1, 0, 8'h33);
    check("R2 lowest bit", firstErrPtr, 10);
  endtask

  task automatic tQueue();
    doReset();
    mhrEnable = 1;
    sendRec(32'h20, 1, 0, 8'hA1);
    sendRec(32'h1000, 1, 0, 8'hB2);
    sendRec(32'h100000, 1, 0, 8'hC3);
    check("R5 count", queueCount, 2);
    check("R5 log kept", hdrLog, rev(mkHdr(8'hA1)));
    check("R5 ptr kept", firstErrPtr, 5);
    check("R5 status", uncorStatus, 32'h101020);
    swWrite(32'h101000);
    check("R9 queued bits kept", uncorStatus, 32'h101020);
    check("R9 count", queueCount, 2);
    swWrite(32'h20);
    check("R7 first pop ptr", firstErrPtr, 12);
    check("R7 first pop hdr", hdrLog, rev(mkHdr(8'hB2)));
    check("R7 count", queueCount, 1);
    check("R7 status", uncorStatus, 32'h101000);
    swWrite(32'h1000);
    check("R7 second pop hdr", hdrLog, rev(mkHdr(8'hC3)));
    check("R7 second pop ptr", firstErrPtr, 20);
    swWrite(32'h100000);
    check("R8 empty queue clears", {hdrLog, firstErrPtr}, 0);
    check("R8 status", uncorStatus, 0);
  endtask

  task automatic tOverflow();
    doReset();
    mhrEnable = 1;
    sendRec(32'h2, 1, 0, 8'h01);
    for (int i = 0; i < 4; i++) sendRec(32'h4 << i, 1, 0, 8'(8'h10 + i));
    check("R5 full count", queueCount, 4);
    check("R6 no pulse before", overflowPulse, 0);
    sendRec(32'h40, 1, 0, 8'h77);
    check("R6 pulse", overflowPulse, 1);
    check("R6 count held", queueCount, 4);
    check("R2 dropped status merged", uncorStatus, 32'h7E);
    @(negedge clk);
    check("R6 pulse one cycle", overflowPulse, 0);
    mhrEnable = 0;
    swWrite(32'h4);
    check("R10 flushed", queueCount, 0);
    check("R10 ptr kept", firstErrPtr, 1);
    check("R10 status", uncorStatus, 32'h7A);
    @(negedge clk);
    swWrValid = 1; swWrData = 0;
    recValid = 1; recStatus = 32'h80; recHdrValid = 1; recHdr = mkHdr(8'h99);
    @(negedge clk);
    swWrValid = 0; recValid = 0;
    check("R12 status unchanged", uncorStatus, 32'h7A);
    check("R12 log unchanged", hdrLog, rev(mkHdr(8'h01)));
  endtask

  initial begin
    tReset();
    tDirectLog();
    tQueue();
    tOverflow();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule